// File: doc/BRIEF.md
# Display Burst-Gap Bus Arbiter

This block divides one external memory bus between a display refresh fetcher and a shared port used by other bus masters, such as a processor or a DMA engine. The display fetcher reads in fixed-length bursts, one access per bus clock. When a burst ends, the arbiter keeps the display side off the bus for a programmed number of bus clocks. During that window the shared port can take the bus. If nobody asks for it, the bus stays idle for the whole window.

The window length comes from an 8-bit field in a 16-bit register. The burst length comes from a display-orientation input and a 2-bit length select. Both settings are captured at fixed points: the register when a gap is loaded, and the length when a burst starts. A change made during a burst or a gap therefore never cuts that burst or gap short.

Top module: `disp_gap_arb`

## Requirements
- R1: After reset, `disp_gnt` and `ext_gnt` are 0 and `reg_rdata` reads 0x0000. The interval field therefore starts at 0, which gives a one-clock gap.
- R2: A write with `reg_we` stores `reg_wdata[7:0]` as the interval field. `reg_rdata[7:0]` returns that field from the next cycle on. `reg_rdata[15:8]` always reads 0, and written upper bits have no effect.
- R3: With `rot_mode` = 0, each display burst holds `disp_gnt` high for exactly 16 consecutive clocks.
- R4: With `rot_mode` = 1, the burst length is 4, 8, 16 or 32 clocks for `burst_sel` = 0, 1, 2 or 3.
- R5: With `disp_req` held and `ext_req` low, consecutive bursts are separated by exactly N+1 clocks with `disp_gnt` low, where N is the interval field.
- R6: During a gap, `ext_gnt` follows `ext_req` in the same cycle. `disp_gnt` and `ext_gnt` are never high together.
- R7: A gap with no shared-port request is not shortened: the bus is idle, with both grants low, for all N+1 clocks.
- R8: If the shared port still holds the bus when the gap expires, it keeps `ext_gnt` until it drops `ext_req`. `disp_gnt` rises in the clock after `ext_req` falls.
- R9: The interval field is copied into the gap counter at the last beat of a burst. A write in that same cycle, or during a gap, affects only the following gap.
- R10: `rot_mode` and `burst_sel` are sampled only when a burst starts. Changing them mid-burst does not alter that burst's length, and the next burst uses the new values.
- R11: When the bus is idle and both requests arrive together, the display fetcher wins and gets `disp_gnt` in the next clock. A shared-port request alone gets `ext_gnt` in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Interval register write strobe |
| reg_wdata | input | 16 | Interval register write data |
| reg_rdata | output | 16 | Interval register read data |
| rot_mode | input | 1 | 1 selects rotated display burst lengths |
| burst_sel | input | 2 | Rotated burst length select |
| disp_req | input | 1 | Display fetcher bus request |
| disp_gnt | output | 1 | Display fetcher grant, one beat per clock |
| ext_req | input | 1 | Shared master port request, held for its access |
| ext_gnt | output | 1 | Shared master port grant |

## Verification
Two events can fall in the same cycle and have to be ordered correctly. The first pair is a register write and the last beat of a burst. The bench places a write on exactly the 16th beat, then checks that the gap right after it still uses the old interval and that only the gap after that uses the new one. The second pair is the gap expiring while the shared port is still on the bus. The bench holds `ext_req` across the expiry and then checks that `disp_gnt` stays low until the clock after `ext_req` falls. Random trials mix intervals, modes and mid-burst mode changes, and compare measured burst and gap lengths with the values computed by the bench.

// File: rtl/disp_gap_arb.sv
module disp_gap_arb #(
  parameter int IW       = 8,
  parameter int RW       = 16,
  parameter int NORM_LEN = 16,
  parameter int ROT_BASE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          rot_mode,
  input  logic [1:0]    burst_sel,
  input  logic          disp_req,
  output logic          disp_gnt,
  input  logic          ext_req,
  output logic          ext_gnt
);
  localparam int MAX_LEN = (ROT_BASE << 3) > NORM_LEN ? (ROT_BASE << 3) : NORM_LEN;
  localparam int CW      = $clog2(MAX_LEN);

  typedef enum logic [1:0] {S_IDLE, S_BURST, S_GAP, S_EXT} st_t;

  st_t           state;
  logic [IW-1:0] intv;
  logic [IW-1:0] gap_cnt;
  logic [CW-1:0] beat_cnt;
  logic [CW-1:0] len_m1;

  assign len_m1    = rot_mode ? CW'((ROT_BASE << burst_sel) - 1) : CW'(NORM_LEN - 1);
  assign disp_gnt  = (state == S_BURST);
  assign ext_gnt   = ext_req && (state == S_GAP || state == S_EXT);
  assign reg_rdata = RW'(intv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intv <= '0;
    else if (reg_we) intv <= reg_wdata[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      gap_cnt  <= '0;
      beat_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (disp_req) begin
            state    <= S_BURST;
            beat_cnt <= len_m1;
          end else if (ext_req) begin
            state <= S_EXT;
          end
        end
        S_BURST: begin
          if (beat_cnt == '0) begin
            state   <= S_GAP;
            gap_cnt <= intv;
          end else begin
            beat_cnt <= beat_cnt - CW'(1);
          end
        end
        S_GAP: begin
          if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - IW'(1);
          end else if (ext_req) begin
            state <= S_EXT;
          end else if (disp_req) begin
            state    <= S_BURST;
            beat_cnt <= len_m1;
          end else begin
            state <= S_IDLE;
          end
        end
        default: begin
          if (!ext_req) begin
            if (disp_req) begin
              state    <= S_BURST;
              beat_cnt <= len_m1;
            end else begin
              state <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  p_reg_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata == RW'($past(reg_wdata[IW-1:0])));

  p_gap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_gnt) |-> gap_cnt == $past(intv));

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_gnt && ext_gnt));

  p_gap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GAP && gap_cnt != '0) |=> (!disp_gnt && gap_cnt == $past(gap_cnt) - IW'(1)));

  p_burst_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_gnt && beat_cnt != '0) |=> disp_gnt);

  p_ext_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_gnt && ext_req) |=> !disp_gnt);
endmodule

// File: tb/disp_gap_arb_bench.sv
module disp_gap_arb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        rot_mode = 1'b0;
  logic [1:0]  burst_sel = '0;
  logic        disp_req = 1'b0;
  logic        disp_gnt;
  logic        ext_req = 1'b0;
  logic        ext_gnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  disp_gap_arb u_disp_gap_arb (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rot_mode(rot_mode), .burst_sel(burst_sel),
    .disp_req(disp_req), .disp_gnt(disp_gnt), .ext_req(ext_req), .ext_gnt(ext_gnt)
  );

  function automatic int exp_len(input bit rot, input int sel);
    return rot ? (4 << sel) : 16;
  endfunction

  function automatic int exp_gap(input int n);
    return n + 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic go_idle();
    disp_req = 1'b0; ext_req = 1'b0;
    repeat (300) step();
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 2000 && !disp_gnt; i++) step();
  endtask

  task automatic meas(input bit flip, output int b, output int g);
    b = 0; g = 0;
    while (disp_gnt && b < 100) begin
      b++;
      if (flip && b == 2) begin
        rot_mode = 1'($urandom); burst_sel = 2'($urandom);
      end
      step();
    end
    while (!disp_gnt && g < 400) begin
      if (ext_gnt) g = g + 1000;
      g++;
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int b, g;
    void'($urandom(32'd4242));
    repeat (3) step();
    chk(disp_gnt == 0 && ext_gnt == 0, "R1 grants", {disp_gnt, ext_gnt}, 0);
    chk(reg_rdata == 0, "R1 rdata", reg_rdata, 0);
    rst_n = 1'b1;
    step();

    // R1/R5: default interval gives a one-clock gap; R3 default length
    disp_req = 1'b1;
    wait_rise();
    meas(1'b0, b, g);
    chk(b == exp_len(0, 0), "R3 normal burst", b, exp_len(0, 0));
    chk(g == exp_gap(0), "R1 reset gap", g, exp_gap(0));
    go_idle();

    // R2: reserved bits
    wr(16'hAB5C);
    chk(reg_rdata == 16'h005C, "R2 readback", reg_rdata, 16'h005C);

    // R7: idle gap of 0x5C+1 clocks, grants low throughout
    disp_req = 1'b1;
    wait_rise();
    meas(1'b0, b, g);
    chk(g == exp_gap(8'h5C), "R7 idle gap", g, exp_gap(8'h5C));
    go_idle();

    // R4: every rotated length
    for (int s = 0; s < 4; s++) begin
      rot_mode = 1'b1; burst_sel = 2'(s);
      wr(16'h0003);
      disp_req = 1'b1;
      wait_rise();
      meas(1'b0, b, g);
      chk(b == exp_len(1, s), "R4 rotated burst", b, exp_len(1, s));
      go_idle();
    end

    // R10: mode change mid-burst
    rot_mode = 1'b1; burst_sel = 2'd0;
    disp_req = 1'b1;
    wait_rise();
    b = 0;
    while (disp_gnt && b < 100) begin
      b++;
      if (b == 2) burst_sel = 2'd3;
      step();
    end
    chk(b == 4, "R10 no truncation", b, 4);
    wait_rise();
    meas(1'b0, b, g);
    chk(b == 32, "R10 new mode next burst", b, 32);
    go_idle();

    // R9: write on the last beat, then write mid-gap
    rot_mode = 1'b0;
    wr(16'd5);
    disp_req = 1'b1;
    wait_rise();
    for (int k = 1; k < 16; k++) step();
    chk(disp_gnt == 1, "R3 beat16 still granted", disp_gnt, 1);
    reg_we = 1'b1; reg_wdata = 16'd30;
    step();
    reg_we = 1'b0;
    g = 0;
    while (!disp_gnt && g < 400) begin g++; step(); end
    chk(g == 6, "R9 same-cycle write uses old", g, 6);
    b = 0;
    while (disp_gnt && b < 100) begin b++; step(); end
    g = 0;
    while (!disp_gnt && g < 400) begin
      g++;
      if (g == 3) begin reg_we = 1'b1; reg_wdata = 16'd2; end
      step();
      reg_we = 1'b0;
    end
    chk(g == 31, "R9 gap in progress untouched", g, 31);
    meas(1'b0, b, g);
    chk(g == 3, "R9 new value next gap", g, 3);
    go_idle();

    // R6/R8: shared port holds across expiry
    wr(16'd20);
    disp_req = 1'b1;
    wait_rise();
    b = 0;
    while (disp_gnt && b < 100) begin b++; step(); end
    step(); step();
    ext_req = 1'b1;
    #1;
    chk(ext_gnt == 1 && disp_gnt == 0, "R6 gap grant", ext_gnt, 1);
    begin
      int bad = 0;
      for (int k = 0; k < 40; k++) begin
        step();
        if (disp_gnt || !ext_gnt) bad++;
      end
      chk(bad == 0, "R8 hold past expiry", bad, 0);
    end
    ext_req = 1'b0;
    #1;
    chk(ext_gnt == 0, "R6 grant follows request", ext_gnt, 0);
    step();
    chk(disp_gnt == 1, "R8 display after release", disp_gnt, 1);
    go_idle();

    // R11: idle priority and idle shared grant
    disp_req = 1'b1; ext_req = 1'b1;
    step();
    chk(disp_gnt == 1 && ext_gnt == 0, "R11 display wins", {disp_gnt, ext_gnt}, 2);
    disp_req = 1'b0;
    b = 0;
    while (disp_gnt && b < 100) begin b++; step(); end
    chk(ext_gnt == 1, "R6 shared gets gap", ext_gnt, 1);
    go_idle();
    ext_req = 1'b1;
    step();
    chk(ext_gnt == 1 && disp_gnt == 0, "R11 shared alone", ext_gnt, 1);
    go_idle();

    // Random trials: R2 R3 R4 R5 R10
    for (int t = 0; t < 40; t++) begin
      int n, s;
      bit r;
      n = int'($urandom_range(0, 255));
      r = 1'($urandom);
      s = int'($urandom_range(0, 3));
      wr({8'($urandom), 8'(n)});
      chk(reg_rdata == 16'(n), "R2 random readback", reg_rdata, n);
      rot_mode = r; burst_sel = 2'(s);
      disp_req = 1'b1;
      wait_rise();
      meas(1'b1, b, g);
      chk(b == exp_len(r, s), "R4 random burst", b, exp_len(r, s));
      chk(g == exp_gap(n), "R5 random gap", g, exp_gap(n));
      go_idle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule